// File: doc/BRIEF.md
# OSD Character Cell Address Generator

This block walks the visible character grid of an on-screen display overlay one dot clock at a time. For each dot it produces the display-RAM row and column of the character cell being drawn, the glyph line index and the glyph pixel column. A downstream fetch stage uses these to read the character code (one of 128 glyphs) and then the glyph bitmap. The glyph ROM, window and border drawing, and colour logic are outside this block.

The horizontal flyback pulse starts each scan line and the vertical flyback pulse starts each frame. Each memory row has a control register with two flags, double height and double width. The caller presents these flags for the row currently shown on `ram_row`. A double-height row fills two screen rows, and the next memory row follows it directly with no filler row. A double-width row shows only even memory columns and stretches every glyph pixel over two dots. Screen rows are counted as they fill up. Once the screen has no row space left, nothing more is shown until the next frame.

Top module: `osd_cell_addr_gen`

## Requirements
- R1: While reset is held, `disp_active` is 0.
- R2: Each clock edge with `h_flyback` high clears the column and dot position. At the first clock edge with `h_flyback` low, the outputs become column 0, glyph dot 0.
- R3: In a normal-width row, `glyph_dot` steps 0..9 on successive dot clocks and `ram_col` then advances by 1. `disp_active` covers exactly 24 cells (240 dots) after flyback, and `ram_col` stays below 24 whenever `disp_active` is 1.
- R4: In a double-width row, each `glyph_dot` value is held for two dot clocks and `ram_col` advances by 2. Only even columns appear, and the active span is still 240 dots.
- R5: Each clock edge with `v_flyback` high returns to memory row 0 and disarms display. The first rising edge of `h_flyback` after that shows glyph line 0 of memory row 0. Each later rising edge advances one scan line.
- R6: In a normal-height row, `glyph_line` follows the scan line 0..15. After scan line 15 the next memory row begins.
- R7: In a double-height row, `glyph_line` advances every second scan line (0..15 over 32 scan lines). The row uses two screen rows, and the next memory row starts right after it.
- R8: The count of used screen rows stops at 10. After that, `disp_active` stays 0 until the next vertical flyback. A double-height row that starts on the last screen row shows only its upper half.
- R9: `disp_active` is 0 on the cycle after any edge sampled with `h_flyback` high and while the display is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_flyback | input | 1 | Horizontal flyback pulse, high during line retrace |
| v_flyback | input | 1 | Vertical flyback pulse, high during frame retrace |
| row_dbl_height | input | 1 | Double-height flag of the memory row on `ram_row` |
| row_dbl_width | input | 1 | Double-width flag of the memory row on `ram_row` |
| ram_row | output | 4 | Display-RAM memory row |
| ram_col | output | 5 | Display-RAM column |
| glyph_line | output | 4 | Glyph line index 0..15 |
| glyph_dot | output | 4 | Pixel column within the glyph 0..9 |
| disp_active | output | 1 | High while a character dot is on screen |

## Verification
The assertions assume that the two row flags stay constant for as long as a memory row is shown. They also assume that the flags change only while the line is in horizontal flyback. The even-column and pixel-hold checks would fire if a flag toggled mid-line. The bench meets these assumptions by deriving both flags from its own row table, indexed by the `ram_row` output. Row advances happen only on a rising edge of the horizontal flyback. The bench changes the vertical flyback only at line boundaries and keeps each line longer than the 240-dot active span, so every line runs to the end of its column range.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int unsigned OSD_CELL_W   = 10;
  localparam int unsigned OSD_CELL_H   = 16;
  localparam int unsigned OSD_COLS     = 24;
  localparam int unsigned OSD_MEM_ROWS = 10;
  localparam int unsigned OSD_SCR_ROWS = 10;
endpackage

// File: rtl/osd_hcount.sv
module osd_hcount #(
  parameter int unsigned CELL_W = 10,
  parameter int unsigned COLS   = 24,
  parameter int unsigned DW     = 4,
  parameter int unsigned CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_flyback,
  input  logic          dbl_w,
  output logic          h_blank,
  output logic          h_run,
  output logic [CW-1:0] col,
  output logic [DW-1:0] pix
);
  logic          blank_q, blank_d;
  logic          half_q, half_d;
  logic [DW-1:0] pix_q, pix_d;
  logic [CW-1:0] col_q, col_d;
  logic          in_span;

  assign in_span = col_q < CW'(COLS);

  always_comb begin
    blank_d = blank_q;
    half_d  = half_q;
    pix_d   = pix_q;
    col_d   = col_q;
    if (h_flyback) begin
      blank_d = 1'b1;
      half_d  = 1'b0;
      pix_d   = '0;
      col_d   = '0;
    end else if (blank_q) begin
      blank_d = 1'b0;
    end else if (in_span) begin
      if (dbl_w && !half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (pix_q == DW'(CELL_W - 1)) begin
          pix_d = '0;
          col_d = col_q + (dbl_w ? CW'(2) : CW'(1));
        end else begin
          pix_d = pix_q + DW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      half_q  <= 1'b0;
      pix_q   <= '0;
      col_q   <= '0;
    end else begin
      blank_q <= blank_d;
      half_q  <= half_d;
      pix_q   <= pix_d;
      col_q   <= col_d;
    end
  end

  assign h_blank = blank_q;
  assign h_run   = !blank_q && in_span;
  assign col     = col_q;
  assign pix     = pix_q;

  assert_dot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_q |-> pix_q < DW'(CELL_W));
  assert_flyback_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_flyback |=> (col_q == '0 && pix_q == '0 && blank_q));
  assert_even_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_run && dbl_w) |-> !col_q[0]);
  assert_pixel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_run && dbl_w && !half_q && !h_flyback) |=> pix_q == $past(pix_q));
endmodule

// File: rtl/osd_vcount.sv
module osd_vcount #(
  parameter int unsigned CELL_H   = 16,
  parameter int unsigned MEM_ROWS = 10,
  parameter int unsigned SCR_ROWS = 10,
  parameter int unsigned LW       = 4,
  parameter int unsigned RW       = 4,
  parameter int unsigned SW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_flyback,
  input  logic          h_flyback,
  input  logic          h_blank,
  input  logic          dbl_h,
  output logic          v_run,
  output logic [RW-1:0] mem_row,
  output logic [LW-1:0] line
);
  logic          armed_q, armed_d;
  logic          second_q, second_d;
  logic [LW-1:0] sline_q, sline_d;
  logic [RW-1:0] mrow_q, mrow_d;
  logic [SW-1:0] srow_q, srow_d;
  logic          line_start;

  assign line_start = h_flyback && !h_blank;

  always_comb begin
    armed_d  = armed_q;
    second_d = second_q;
    sline_d  = sline_q;
    mrow_d   = mrow_q;
    srow_d   = srow_q;
    if (v_flyback) begin
      armed_d  = 1'b0;
      second_d = 1'b0;
      sline_d  = '0;
      mrow_d   = '0;
      srow_d   = '0;
    end else if (line_start) begin
      if (!armed_q) begin
        armed_d = 1'b1;
      end else if (srow_q < SW'(SCR_ROWS)) begin
        if (sline_q == LW'(CELL_H - 1)) begin
          sline_d = '0;
          srow_d  = srow_q + SW'(1);
          if (dbl_h && !second_q) begin
            second_d = 1'b1;
          end else begin
            second_d = 1'b0;
            mrow_d   = mrow_q + RW'(1);
          end
        end else begin
          sline_d = sline_q + LW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      second_q <= 1'b0;
      sline_q  <= '0;
      mrow_q   <= '0;
      srow_q   <= '0;
    end else begin
      armed_q  <= armed_d;
      second_q <= second_d;
      sline_q  <= sline_d;
      mrow_q   <= mrow_d;
      srow_q   <= srow_d;
    end
  end

  assign v_run   = armed_q && (srow_q < SW'(SCR_ROWS)) && (mrow_q < RW'(MEM_ROWS));
  assign mem_row = mrow_q;
  assign line    = dbl_h ? ((second_q ? LW'(CELL_H / 2) : LW'(0)) + (sline_q >> 1))
                         : sline_q;

  assert_row_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srow_q <= SW'(SCR_ROWS));
  assert_exhaust_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && srow_q == SW'(SCR_ROWS) && !v_flyback) |=> srow_q == SW'(SCR_ROWS));
  assert_frame_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v_flyback |=> (!armed_q && mrow_q == '0 && srow_q == '0));
  assert_mem_behind_screen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, mrow_q} <= {1'b0, srow_q});
endmodule

// File: rtl/osd_cell_addr_gen.sv
module osd_cell_addr_gen
  import osd_pkg::*;
#(
  parameter int unsigned CELL_W   = OSD_CELL_W,
  parameter int unsigned CELL_H   = OSD_CELL_H,
  parameter int unsigned COLS     = OSD_COLS,
  parameter int unsigned MEM_ROWS = OSD_MEM_ROWS,
  parameter int unsigned SCR_ROWS = OSD_SCR_ROWS,
  localparam int unsigned DW = $clog2(CELL_W),
  localparam int unsigned LW = $clog2(CELL_H),
  localparam int unsigned CW = $clog2(COLS + 2),
  localparam int unsigned RW = $clog2(MEM_ROWS + 1),
  localparam int unsigned SW = $clog2(SCR_ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_flyback,
  input  logic          v_flyback,
  input  logic          row_dbl_height,
  input  logic          row_dbl_width,
  output logic [RW-1:0] ram_row,
  output logic [CW-1:0] ram_col,
  output logic [LW-1:0] glyph_line,
  output logic [DW-1:0] glyph_dot,
  output logic          disp_active
);
  logic [1:0] rst_sync;
  logic       core_rst_n;
  logic       h_blank, h_run, v_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  osd_hcount #(.CELL_W(CELL_W), .COLS(COLS), .DW(DW), .CW(CW)) u_h (
    .clk(clk), .rst_n(core_rst_n), .h_flyback(h_flyback), .dbl_w(row_dbl_width),
    .h_blank(h_blank), .h_run(h_run), .col(ram_col), .pix(glyph_dot)
  );

  osd_vcount #(.CELL_H(CELL_H), .MEM_ROWS(MEM_ROWS), .SCR_ROWS(SCR_ROWS),
               .LW(LW), .RW(RW), .SW(SW)) u_v (
    .clk(clk), .rst_n(core_rst_n), .v_flyback(v_flyback), .h_flyback(h_flyback),
    .h_blank(h_blank), .dbl_h(row_dbl_height),
    .v_run(v_run), .mem_row(ram_row), .line(glyph_line)
  );

  assign disp_active = h_run && v_run;

  assert_reset_idle_R1: assert property (@(posedge clk) !core_rst_n |-> !disp_active);
  assert_col_bound_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    disp_active |-> ram_col < CW'(COLS));
  assert_flyback_dark_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    h_flyback |=> !disp_active);
endmodule

// File: tb/sim_osd_cell_addr_gen.sv
module sim_osd_cell_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_flyback = 1'b1;
  logic v_flyback = 1'b1;
  logic row_dbl_height, row_dbl_width;
  logic [3:0] ram_row;
  logic [4:0] ram_col;
  logic [3:0] glyph_line;
  logic [3:0] glyph_dot;
  logic disp_active;

  logic [15:0] tab_h = '0;
  logic [15:0] tab_w = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign row_dbl_height = tab_h[ram_row];
  assign row_dbl_width  = tab_w[ram_row];

  osd_cell_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .h_flyback(h_flyback), .v_flyback(v_flyback),
    .row_dbl_height(row_dbl_height), .row_dbl_width(row_dbl_width),
    .ram_row(ram_row), .ram_col(ram_col), .glyph_line(glyph_line),
    .glyph_dot(glyph_dot), .disp_active(disp_active)
  );

  // reference model: x = dots since flyback end, sl = scan lines since arming
  int x, sl;
  bit hb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x = -1; sl = -1; hb = 1'b1;
    end else begin
      if (v_flyback) sl = -1;
      else if (h_flyback && !hb) sl = sl + 1;
      if (h_flyback) x = -1;
      else x = x + 1;
      hb = h_flyback;
    end
  end

  bit e_act; int e_row, e_col, e_line, e_dot; string e_tag;

  task automatic expect_now();
    int m, base, srow, r, ht;
    bit found;
    e_act = 0; e_row = 0; e_col = 0; e_line = 0; e_dot = 0;
    if (x < 0) begin e_tag = "R9"; return; end
    if (sl < 0) begin e_tag = "R5"; return; end
    m = 0; base = 0; srow = 0; found = 0;
    while (!found && m < 10) begin
      ht = tab_h[m] ? 32 : 16;
      if (sl < base + ht) found = 1;
      else begin base += ht; srow += tab_h[m] ? 2 : 1; m++; end
    end
    if (!found) begin e_tag = "R8"; return; end
    r = sl - base;
    if (srow + r / 16 >= 10) begin e_tag = "R8"; return; end
    if (x >= 240) begin e_tag = tab_w[m] ? "R4" : "R3"; return; end
    e_act = 1;
    e_row = m;
    e_line = tab_h[m] ? r / 2 : r;
    if (tab_w[m]) begin e_col = (x / 20) * 2; e_dot = (x % 20) / 2; end
    else begin e_col = x / 10; e_dot = x % 10; end
    if (x == 0) e_tag = "R2";
    else if (e_line != r % 16 || tab_h[m]) e_tag = "R7";
    else if (tab_w[m]) e_tag = "R4";
    else e_tag = "R6";
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      expect_now();
      checks++;
      if (disp_active !== e_act ||
          (e_act && (ram_row !== 4'(e_row) || ram_col !== 5'(e_col) ||
                     glyph_line !== 4'(e_line) || glyph_dot !== 4'(e_dot)))) begin
        fails++;
        $display("FAIL %s t=%0t act/row/col/line/dot actual=%0b/%0d/%0d/%0d/%0d expected=%0b/%0d/%0d/%0d/%0d",
                 e_tag, $time, disp_active, ram_row, ram_col, glyph_line, glyph_dot,
                 e_act, e_row, e_col, e_line, e_dot);
      end
    end
  end

  task automatic scan_line();
    @(posedge clk); #1 h_flyback = 1'b1;
    repeat (3) @(posedge clk);
    #1 h_flyback = 1'b0;
    repeat (246) @(posedge clk);
  endtask

  task automatic frame(input logic [15:0] th, input logic [15:0] tw);
    @(posedge clk); #1 v_flyback = 1'b1;
    tab_h = th; tab_w = tw;
    repeat (2) scan_line();
    @(posedge clk); #1 v_flyback = 1'b0;
    repeat (175) scan_line();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (disp_active !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset active actual=%0b expected=0", disp_active);
    end
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    // all rows normal size
    frame(16'h0000, 16'h0000);
    // mixed: row 1 tall, row 3 wide, row 4 tall and wide; row 8 beyond row space
    frame(16'h0112, 16'h0018);
    // tall row landing on the last screen row shows only its upper half
    frame(16'h0200, 16'h0200);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule